// File: doc/BRIEF.md
# Selectable Frame and Multiframe Timing Generator

This block produces the bit, timeslot, frame and multiframe timing for two time-division buses that share one bit clock: a local bus and an expansion bus. A two-bit framing mode sets the frame length in bits and the number of frames in a multiframe. The two buses do not always get the same geometry. An interface-select input picks which mode combinations are legal and decides whether the expansion bus carries a multiframe strobe at all.

For each bus the block outputs the position of the current bit in the frame, the timeslot that bit belongs to, a one-cycle frame strobe and a one-cycle multiframe strobe. In the 193-bit format, bit 0 is a lone framing bit and belongs to no slot. An external frame-sync pulse restarts both frames at once. The mode and interface select are sampled only at a frame boundary, so a new geometry never cuts a frame short. A flag reports any mode combination that the rules forbid. The block has no streaming data path: every pin is a plain control or status signal.

Top module: `frame_timing_gen`

## Requirements
- R1: While reset is low and in the first sampled cycle after it, both bit counters read 0 and all four strobes and the invalid flag are low. The active configuration after reset is mode 01 with interface select 0.
- R2: Expansion frame length by active mode: 00 gives 193 bits, 01 gives 256, 10 gives 512 and 11 gives 1024. The bit index counts 0 up to length-1 and then returns to 0.
- R3: Local frame length is 193 bits in mode 00 and 256 bits in modes 01, 10 and 11.
- R4: A multiframe holds 12 frames in mode 00 and 16 frames in every other mode. A multiframe strobe is raised only together with a frame strobe.
- R5: In 193-bit frames, bit 0 has slot-valid low and slot index 0, and bit b in 1..192 maps to slot (b-1)/8. In all other frames bit b maps to slot b/8 and slot-valid is high.
- R6: A high fsync_in sampled at a clock edge sets both bit counters to 0 at that edge and raises both frame strobes.
- R7: A frame strobe is high for exactly the one cycle in which a bit counter has just returned to 0, whether from a wrap or from fsync_in.
- R8: frm_mode and bus_sel are taken into the active configuration only at a frame boundary, meaning fsync_in or the end of an expansion frame. The current frame keeps its old length.
- R9: mode_bad is high when the active configuration is interface select 0 with mode 00, or interface select 1 with mode 10 or 11. It is low otherwise, and it changes only at a frame boundary.
- R10: With interface select 0, exp_mfs stays low. The local multiframe strobe keeps running in that case, including the invalid mode 00, where it runs with 12-frame multiframes in step with the frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_in | input | 1 | External frame sync, one-cycle pulse |
| frm_mode | input | 2 | Framing mode selection |
| bus_sel | input | 1 | Interface select (0 or 1) |
| loc_bit | output | 10 | Local bus bit index within frame |
| loc_slot | output | 7 | Local bus timeslot index |
| loc_slot_vld | output | 1 | Local bit lies inside a timeslot |
| loc_fs | output | 1 | Local frame strobe |
| loc_mfs | output | 1 | Local multiframe strobe |
| exp_bit | output | 10 | Expansion bus bit index within frame |
| exp_slot | output | 7 | Expansion bus timeslot index |
| exp_slot_vld | output | 1 | Expansion bit lies inside a timeslot |
| exp_fs | output | 1 | Expansion frame strobe |
| exp_mfs | output | 1 | Expansion multiframe strobe |
| mode_bad | output | 1 | Active configuration is forbidden |

## Verification
The assertions take fsync_in to be an input that may arrive at any cycle. They take frm_mode and bus_sel to be allowed to change at any cycle too, since the block alone decides when it samples them. The bench drives every input on the falling clock edge, so each rising edge sees a stable value. It pulses fsync_in for exactly one cycle. It changes the mode in the middle of a frame to test that the change is held off until the frame ends. Multiframe periods are measured with the configuration held constant, because a multiframe that straddles a change of configuration has no single expected length.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef struct packed {
    logic [1:0] mode;
    logic       sel;
  } ftg_cfg_t;

  // frame length in bit clocks for one bus
  function automatic int frame_len(input logic [1:0] mode, input logic is_exp);
    if (mode == 2'b00) return 193;
    if (!is_exp)       return 256;
    case (mode)
      2'b01:   return 256;
      2'b10:   return 512;
      default: return 1024;
    endcase
  endfunction

  function automatic int mf_len(input logic [1:0] mode);
    return (mode == 2'b00) ? 12 : 16;
  endfunction

  function automatic logic cfg_bad(input logic [1:0] mode, input logic sel);
    return sel ? mode[1] : (mode == 2'b00);
  endfunction

endpackage

// File: rtl/ftg_cfg.sv
module ftg_cfg (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [1:0]       mode_in,
  input  logic             sel_in,
  output ftg_pkg::ftg_cfg_t act,
  output logic             bad
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '{mode: 2'b01, sel: 1'b0};
      bad <= 1'b0;
    end else if (upd) begin
      act <= '{mode: mode_in, sel: sel_in};
      bad <= ftg_pkg::cfg_bad(mode_in, sel_in);
    end
  end
endmodule

// File: rtl/ftg_bus.sv
module ftg_bus #(
  parameter int BIT_W  = 10,
  parameter int SLOT_W = 7,
  parameter int FRM_W  = 4,
  parameter bit IS_EXP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [1:0]        mode,
  input  logic              mf_en,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              slot_vld,
  output logic              fs,
  output logic              mfs,
  output logic              last
);
  localparam int SLOT_SH   = 3;
  localparam int SLOT_BITS = 1 << SLOT_SH;

  logic [BIT_W-1:0] bit_q;
  logic [FRM_W-1:0] frm_q;
  logic             fs_q, mfs_q;
  int               len, mfl;
  logic             has_fbit, bound, frm_wrap;
  logic [BIT_W-1:0] pay;

  always_comb begin
    len      = ftg_pkg::frame_len(mode, IS_EXP);
    mfl      = ftg_pkg::mf_len(mode);
    has_fbit = (len % SLOT_BITS) != 0;
    last     = (bit_q == BIT_W'(len - 1));
    bound    = fsync | last;
    frm_wrap = (frm_q >= FRM_W'(mfl - 1));
    pay      = has_fbit ? (bit_q - BIT_W'(1)) : bit_q;
    slot_vld = !(has_fbit && (bit_q == '0));
    slot_idx = slot_vld ? SLOT_W'(pay >> SLOT_SH) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      frm_q <= '0;
      fs_q  <= 1'b0;
      mfs_q <= 1'b0;
    end else begin
      bit_q <= bound ? '0 : bit_q + BIT_W'(1);
      if (bound) frm_q <= frm_wrap ? '0 : frm_q + FRM_W'(1);
      fs_q  <= bound;
      mfs_q <= bound & frm_wrap & mf_en;
    end
  end

  assign bit_idx = bit_q;
  assign fs      = fs_q;
  assign mfs     = mfs_q;
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen #(
  parameter int BIT_W  = 10,
  parameter int SLOT_W = 7,
  parameter int FRM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_in,
  input  logic [1:0]        frm_mode,
  input  logic              bus_sel,
  output logic [BIT_W-1:0]  loc_bit,
  output logic [SLOT_W-1:0] loc_slot,
  output logic              loc_slot_vld,
  output logic              loc_fs,
  output logic              loc_mfs,
  output logic [BIT_W-1:0]  exp_bit,
  output logic [SLOT_W-1:0] exp_slot,
  output logic              exp_slot_vld,
  output logic              exp_fs,
  output logic              exp_mfs,
  output logic              mode_bad
);
  ftg_pkg::ftg_cfg_t act;
  logic loc_last, exp_last, cfg_upd;

  // local frames always divide expansion frames, so both end together
  assign cfg_upd = fsync_in | (exp_last & loc_last);

  ftg_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .upd(cfg_upd),
    .mode_in(frm_mode), .sel_in(bus_sel), .act(act), .bad(mode_bad)
  );

  ftg_bus #(.BIT_W(BIT_W), .SLOT_W(SLOT_W), .FRM_W(FRM_W), .IS_EXP(1'b0)) u_loc (
    .clk(clk), .rst_n(rst_n), .fsync(fsync_in), .mode(act.mode), .mf_en(1'b1),
    .bit_idx(loc_bit), .slot_idx(loc_slot), .slot_vld(loc_slot_vld),
    .fs(loc_fs), .mfs(loc_mfs), .last(loc_last)
  );

  ftg_bus #(.BIT_W(BIT_W), .SLOT_W(SLOT_W), .FRM_W(FRM_W), .IS_EXP(1'b1)) u_exp (
    .clk(clk), .rst_n(rst_n), .fsync(fsync_in), .mode(act.mode), .mf_en(act.sel),
    .bit_idx(exp_bit), .slot_idx(exp_slot), .slot_vld(exp_slot_vld),
    .fs(exp_fs), .mfs(exp_mfs), .last(exp_last)
  );
endmodule

// File: rtl/ftg_chk.sv
module ftg_chk #(
  parameter int BIT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fsync_in,
  input logic [BIT_W-1:0] loc_bit,
  input logic [BIT_W-1:0] exp_bit,
  input logic             loc_fs,
  input logic             exp_fs,
  input logic             loc_mfs,
  input logic             exp_mfs,
  input logic             loc_slot_vld,
  input logic             mode_bad
);
  // R7
  fs_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_fs |-> exp_bit == '0) and (loc_fs |-> loc_bit == '0));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !exp_fs) |-> exp_bit == $past(exp_bit) + BIT_W'(1));

  // R4
  mfs_with_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_mfs |-> loc_fs) and (exp_mfs |-> exp_fs));

  // R5
  fbit_only_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_slot_vld |-> loc_bit == '0);

  // R6
  fsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_in |=> (exp_bit == '0 && loc_bit == '0 && exp_fs && loc_fs));

  // R9
  flag_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_bad) |-> exp_fs);
endmodule

bind frame_timing_gen ftg_chk #(.BIT_W(BIT_W)) u_ftg_chk (
  .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in),
  .loc_bit(loc_bit), .exp_bit(exp_bit), .loc_fs(loc_fs), .exp_fs(exp_fs),
  .loc_mfs(loc_mfs), .exp_mfs(exp_mfs), .loc_slot_vld(loc_slot_vld),
  .mode_bad(mode_bad)
);

// File: tb/test_frame_timing_gen.sv
`timescale 1ns/1ps
module test_frame_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync_in = 1'b0;
  logic [1:0] frm_mode = 2'b01;
  logic       bus_sel = 1'b0;
  logic [9:0] loc_bit, exp_bit;
  logic [6:0] loc_slot, exp_slot;
  logic       loc_slot_vld, loc_fs, loc_mfs, exp_slot_vld, exp_fs, exp_mfs, mode_bad;

  int n_chk = 0;
  int n_bad = 0;
  int exp_mfs_seen = 0;

  always #4 clk = ~clk;

  frame_timing_gen i_frame_timing_gen (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .frm_mode(frm_mode), .bus_sel(bus_sel),
    .loc_bit(loc_bit), .loc_slot(loc_slot), .loc_slot_vld(loc_slot_vld),
    .loc_fs(loc_fs), .loc_mfs(loc_mfs),
    .exp_bit(exp_bit), .exp_slot(exp_slot), .exp_slot_vld(exp_slot_vld),
    .exp_fs(exp_fs), .exp_mfs(exp_mfs), .mode_bad(mode_bad)
  );

  always @(negedge clk) if (exp_mfs) exp_mfs_seen++;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_cfg(input logic [1:0] m, input logic s);
    frm_mode = m; bus_sel = s; fsync_in = 1'b1;
    tick(1);
    fsync_in = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    check(exp_bit == 0 && loc_bit == 0, "R1 bits in reset", exp_bit, 0);
    check({loc_fs, loc_mfs, exp_fs, exp_mfs, mode_bad} == 0, "R1 strobes in reset",
          {loc_fs, loc_mfs, exp_fs, exp_mfs, mode_bad}, 0);
    rst_n = 1'b1;
    tick(1);
    check(exp_bit == 1 && !exp_fs, "R1 first count", exp_bit, 1);
    tick(255);
    check(exp_bit == 0 && exp_fs, "R1 default 256-bit frame", exp_bit, 0);
    check(mode_bad == 0, "R1 default config valid", mode_bad, 0);
  endtask

  task automatic t_len(input logic [1:0] m, input logic s, input int el, input int ll);
    sync_cfg(m, s);
    check(loc_bit == 0 && loc_fs, "R6 local restart", loc_bit, 0);
    tick(ll - 1);
    check(loc_bit == ll - 1 && !loc_fs, "R3 local last bit", loc_bit, ll - 1);
    tick(1);
    check(loc_bit == 0 && loc_fs, "R3 R7 local wrap", loc_bit, 0);
    sync_cfg(m, s);
    tick(el - 1);
    check(exp_bit == el - 1 && !exp_fs, "R2 exp last bit", exp_bit, el - 1);
    check(exp_slot == ((el % 8 != 0) ? 23 : el / 8 - 1), "R5 exp last slot", exp_slot,
          (el % 8 != 0) ? 23 : el / 8 - 1);
    tick(1);
    check(exp_bit == 0 && exp_fs, "R2 R7 exp wrap", exp_bit, 0);
    tick(1);
    check(!exp_fs, "R7 strobe one cycle", exp_fs, 0);
  endtask

  task automatic t_slots();
    sync_cfg(2'b00, 1'b1);
    check(!loc_slot_vld && !exp_slot_vld && loc_slot == 0, "R5 framing bit", loc_slot_vld, 0);
    tick(1);
    check(loc_slot_vld && loc_slot == 0, "R5 bit1 slot0", loc_slot, 0);
    tick(8);
    check(loc_slot == 1 && exp_slot == 1, "R5 bit9 slot1", loc_slot, 1);
    tick(183);
    check(loc_bit == 192 && loc_slot == 23, "R5 bit192 slot23", loc_slot, 23);
    sync_cfg(2'b01, 1'b1);
    check(loc_slot_vld && loc_slot == 0, "R5 no framing bit", loc_slot_vld, 1);
    tick(8);
    check(loc_slot == 1, "R5 bit8 slot1", loc_slot, 1);
  endtask

  task automatic t_fsync();
    sync_cfg(2'b01, 1'b0);
    tick(50);
    check(exp_bit == 50, "R6 pre-sync count", exp_bit, 50);
    fsync_in = 1'b1;
    tick(1);
    fsync_in = 1'b0;
    check(exp_bit == 0 && loc_bit == 0 && exp_fs && loc_fs, "R6 mid-frame restart", exp_bit, 0);
  endtask

  task automatic t_flag();
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m = 2'(i % 4);
      logic s = 1'(i / 4);
      bit want = s ? m[1] : (m == 2'b00);
      sync_cfg(m, s);
      check(mode_bad == want, "R9 invalid flag", mode_bad, want);
    end
  endtask

  task automatic t_boundary();
    sync_cfg(2'b01, 1'b1);
    tick(100);
    frm_mode = 2'b11;
    tick(1);
    check(mode_bad == 0 && exp_bit == 101, "R8 held mid-frame", mode_bad, 0);
    tick(154);
    check(exp_bit == 255 && mode_bad == 0, "R8 old length kept", exp_bit, 255);
    tick(1);
    check(exp_bit == 0 && exp_fs && mode_bad, "R8 R9 taken at boundary", mode_bad, 1);
    tick(256);
    check(exp_bit == 256 && loc_bit == 0, "R8 new 1024 frame", exp_bit, 256);
  endtask

  task automatic mf_period(input bit on_exp, output int per);
    int n = 0;
    per = -1;
    while (!(on_exp ? exp_mfs : loc_mfs) && n < 40000) begin tick(1); n++; end
    if (n >= 40000) return;
    tick(1);
    n = 1;
    while (!(on_exp ? exp_mfs : loc_mfs) && n < 40000) begin tick(1); n++; end
    if (n < 40000) per = n;
  endtask

  task automatic t_multi(input logic [1:0] m, input logic s, input int lp, input int ep);
    int per;
    sync_cfg(m, s);
    exp_mfs_seen = 0;
    mf_period(1'b0, per);
    check(per == lp, "R4 local multiframe period", per, lp);
    if (s) begin
      mf_period(1'b1, per);
      check(per == ep, "R4 exp multiframe period", per, ep);
    end else begin
      check(exp_mfs_seen == 0, "R10 no exp multiframe", exp_mfs_seen, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_len(2'b00, 1'b1, 193, 193);
    t_len(2'b01, 1'b1, 256, 256);
    t_len(2'b10, 1'b0, 512, 256);
    t_len(2'b11, 1'b0, 1024, 256);
    t_slots();
    t_fsync();
    t_flag();
    t_boundary();
    t_multi(2'b00, 1'b1, 12 * 193, 12 * 193);
    t_multi(2'b11, 1'b1, 16 * 256, 16 * 1024);
    t_multi(2'b00, 1'b0, 12 * 193, 0);
    t_multi(2'b10, 1'b0, 16 * 256, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule